// File: doc/BRIEF.md
# Timestamp Capture Input Qualifier

This block screens a small set of general-purpose input pins that may trigger clock-capture events for a precision time protocol timer. Each pin is first brought into the clock domain through a flop chain. A per-pin polarity setting then picks which level counts as active. A width qualifier only accepts an active level that persists for a programmable number of cycles. Short glitches are dropped before they can reach any state.

A qualified event does three things in the cycle it fires. It emits a one-cycle capture strobe to an external timestamp latch. One cycle later it sets that pin's capture status bit. If timer clearing is enabled, it also clears the timer interrupt status bit at that same later edge. Software control is modelled as plain inputs: a write-one-to-clear strobe with a bit mask, and a per-bit enable vector. The interrupt line is active whenever any status bit has its enable set.

Top module: `ts_capture_qualifier`

## Requirements
- R1: After reset, all status bits, all capture strobes and the interrupt output are 0.
- R2: If a configured input pin holds its active level for at least MIN_ACTIVE_CYCLES consecutive clocks (5 by default), exactly one capture strobe fires for that pin. The strobe is high for one cycle, in the 7th clock cycle after the pin changes at the default settings (two synchroniser stages plus five counted cycles).
- R3: If the pin is active for fewer than MIN_ACTIVE_CYCLES clocks, it gives no strobe, no status change and no timer clear.
- R4: Each pin has a polarity bit. When it is 0, a high level is active (rising edge). When it is 1, a low level is active (falling edge). The opposite transition never starts an event.
- R5: Each active pulse fires at most once, however long it lasts. The pin must return to its inactive level before it can fire again.
- R6: A pin whose input-enable bit is 0 never produces a strobe or a status change.
- R7: Status bit i (for i below NUM_PINS) is set by pin i's event one clock after its strobe. Status bits are cleared by a clear write with a 1 in that mask position. If a set and a clear for the same bit land in the same cycle, the bit stays set.
- R8: Status bit NUM_PINS is the timer interrupt bit, and it is set by the timer set input. While timer clearing is enabled, any qualified event clears this bit at the same edge that sets the capture bit. While timer clearing is disabled, events leave it alone. A hardware set beats both kinds of clear.
- R9: The interrupt output is 1 exactly when some status bit and its enable bit (same position) are both 1. A set status bit with a 0 enable does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NUM_PINS | Raw asynchronous capture pins |
| pin_is_input | input | NUM_PINS | Per-pin capture enable (pin configured as input) |
| pin_fall_active | input | NUM_PINS | Per-pin polarity: 1 = low level / falling edge active |
| timer_clr_en | input | 1 | Allows qualified events to clear the timer status bit |
| timer_int_set | input | 1 | Hardware set of the timer status bit |
| sts_clr_wr | input | 1 | Write strobe for the write-one-to-clear of status |
| sts_clr_mask | input | NUM_PINS+1 | Bits to clear; bit NUM_PINS is the timer bit |
| irq_en | input | NUM_PINS+1 | Interrupt enable per status bit |
| cap_strobe | output | NUM_PINS | One-cycle capture pulse per pin |
| irq_status | output | NUM_PINS+1 | Status bits; bit i = pin i capture, bit NUM_PINS = timer |
| irq_out | output | 1 | Combined interrupt |

## Verification
A corrupted width counter or arming flag shows up at the strobe ports as an early, late, missing or doubled pulse. A scoreboard that knows the exact cycle of each expected strobe catches it within a cycle of the predicted slot. A wrong status update shows on irq_status and irq_out at the edge after the strobe. Pulses one cycle short of the threshold, held pulses and same-cycle set/clear collisions are the stimuli that expose an off-by-one or a priority error.

// File: rtl/tscq_pkg.sv
package tscq_pkg;

    typedef enum logic {
        ACT_HIGH = 1'b0,
        ACT_LOW  = 1'b1
    } act_pol_e;

    // A synchronised level is active when it differs from the polarity bit.
    function automatic logic lvl_active(logic lvl, act_pol_e pol);
        return lvl ^ logic'(pol);
    endfunction

endpackage

// File: rtl/tscq_sync.sv
module tscq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tscq_pin_qual.sv
module tscq_pin_qual
    import tscq_pkg::*;
#(
    parameter int MIN_ACTIVE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_sync,
    input  logic is_input,
    input  logic fall_active,
    output logic strobe
);
    localparam int CNT_W = $clog2(MIN_ACTIVE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(MIN_ACTIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MIN_ACTIVE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             strobe;
    } qual_t;

    qual_t st_d, st_q;
    logic  active;
    logic  fire;

    always_comb begin
        active = is_input && lvl_active(lvl_sync, act_pol_e'(fall_active));
        fire   = active && st_q.armed && (st_q.cnt == CNT_FIRE);

        st_d        = st_q;
        st_d.strobe = fire;

        if (!active)                   st_d.cnt = '0;
        else if (st_q.cnt != CNT_SAT)  st_d.cnt = st_q.cnt + 1'b1;

        if (!is_input)      st_d.armed = 1'b0;
        else if (!active)   st_d.armed = 1'b1;
        else if (fire)      st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.strobe;
endmodule

// File: rtl/tscq_status_regs.sv
module tscq_status_regs #(
    parameter int NUM_PINS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cap_set,
    input  logic                timer_clr_en,
    input  logic                timer_int_set,
    input  logic                sts_clr_wr,
    input  logic [NUM_PINS:0]   sts_clr_mask,
    input  logic [NUM_PINS:0]   irq_en,
    output logic [NUM_PINS:0]   status,
    output logic                irq
);
    localparam int TMR_BIT = NUM_PINS;

    typedef struct packed {
        logic [NUM_PINS:0] sts;
    } regs_t;

    regs_t st_d, st_q;
    logic [NUM_PINS:0] sw_clr;
    logic              hw_tmr_clr;

    always_comb begin
        sw_clr     = sts_clr_wr ? sts_clr_mask : '0;
        hw_tmr_clr = timer_clr_en && (|cap_set);
        st_d       = st_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            st_d.sts[i] = cap_set[i] || (st_q.sts[i] && !sw_clr[i]);
        end
        st_d.sts[TMR_BIT] = timer_int_set ||
                            (st_q.sts[TMR_BIT] && !sw_clr[TMR_BIT] && !hw_tmr_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.sts;
    assign irq    = |(st_q.sts & irq_en);
endmodule

// File: rtl/ts_capture_qualifier.sv
module ts_capture_qualifier #(
    parameter int NUM_PINS          = 2,
    parameter int SYNC_STAGES       = 2,
    parameter int MIN_ACTIVE_CYCLES = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_is_input,
    input  logic [NUM_PINS-1:0] pin_fall_active,
    input  logic                timer_clr_en,
    input  logic                timer_int_set,
    input  logic                sts_clr_wr,
    input  logic [NUM_PINS:0]   sts_clr_mask,
    input  logic [NUM_PINS:0]   irq_en,
    output logic [NUM_PINS-1:0] cap_strobe,
    output logic [NUM_PINS:0]   irq_status,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] lvl_sync;

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            tscq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (pin_in[p]),
                .dout (lvl_sync[p])
            );
            tscq_pin_qual #(.MIN_ACTIVE_CYCLES(MIN_ACTIVE_CYCLES)) u_qual (
                .clk        (clk),
                .rst_n      (rst_n),
                .lvl_sync   (lvl_sync[p]),
                .is_input   (pin_is_input[p]),
                .fall_active(pin_fall_active[p]),
                .strobe     (cap_strobe[p])
            );
        end
    endgenerate

    tscq_status_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_set      (cap_strobe),
        .timer_clr_en (timer_clr_en),
        .timer_int_set(timer_int_set),
        .sts_clr_wr   (sts_clr_wr),
        .sts_clr_mask (sts_clr_mask),
        .irq_en       (irq_en),
        .status       (irq_status),
        .irq          (irq_out)
    );
endmodule

// File: rtl/tscq_checker.sv
module tscq_checker #(
    parameter int NUM_PINS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_is_input,
    input logic                timer_clr_en,
    input logic                timer_int_set,
    input logic                sts_clr_wr,
    input logic [NUM_PINS:0]   sts_clr_mask,
    input logic [NUM_PINS:0]   irq_en,
    input logic [NUM_PINS-1:0] cap_strobe,
    input logic [NUM_PINS:0]   irq_status,
    input logic                irq_out
);
    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                cap_strobe[i] |=> !cap_strobe[i]);
            p_input_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !pin_is_input[i] |=> !cap_strobe[i]);
            p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
                cap_strobe[i] |=> irq_status[i]);
            p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_clr_wr && sts_clr_mask[i] && !cap_strobe[i]) |=> !irq_status[i]);
            p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_strobe[i] && irq_en[i]) |=> irq_out);
        end
    endgenerate

    p_timer_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_int_set |=> irq_status[NUM_PINS]);
    p_timer_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cap_strobe) && timer_clr_en && !timer_int_set) |=> !irq_status[NUM_PINS]);
    p_idle_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (irq_status == '0 && !irq_out));
endmodule

bind ts_capture_qualifier tscq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_is_input (pin_is_input),
    .timer_clr_en (timer_clr_en),
    .timer_int_set(timer_int_set),
    .sts_clr_wr   (sts_clr_wr),
    .sts_clr_mask (sts_clr_mask),
    .irq_en       (irq_en),
    .cap_strobe   (cap_strobe),
    .irq_status   (irq_status),
    .irq_out      (irq_out)
);

// File: tb/sim_ts_capture_qualifier.sv
module sim_ts_capture_qualifier;
    localparam int NP  = 2;
    localparam int LAT = 7;   // R2: change-to-strobe latency at default settings

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_is_input = '1;
    logic [NP-1:0] pin_fall_active = '0;
    logic          timer_clr_en = 1'b1;
    logic          timer_int_set = 1'b0;
    logic          sts_clr_wr = 1'b0;
    logic [NP:0]   sts_clr_mask = '0;
    logic [NP:0]   irq_en = '1;
    logic [NP-1:0] cap_strobe;
    logic [NP:0]   irq_status;
    logic          irq_out;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int exp_pin[$];
    int exp_cyc[$];

    ts_capture_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_is_input(pin_is_input),
        .pin_fall_active(pin_fall_active), .timer_clr_en(timer_clr_en),
        .timer_int_set(timer_int_set), .sts_clr_wr(sts_clr_wr),
        .sts_clr_mask(sts_clr_mask), .irq_en(irq_en), .cap_strobe(cap_strobe),
        .irq_status(irq_status), .irq_out(irq_out)
    );

    always #10 clk = ~clk;            // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected strobes from the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] < cyc) begin
                chk(0, "R2 missing strobe", exp_pin[0], exp_cyc[0]);
                void'(exp_pin.pop_front());
                void'(exp_cyc.pop_front());
            end
            for (int p = 0; p < NP; p++) begin
                if (cap_strobe[p]) begin
                    if (exp_cyc.size() == 0) begin
                        chk(0, "R2/R3/R5 unexpected strobe", p, -1);
                    end else begin
                        chk(exp_pin[0] == p && exp_cyc[0] == cyc,
                            "R2 strobe pin/cycle", p * 100000 + cyc,
                            exp_pin[0] * 100000 + exp_cyc[0]);
                        void'(exp_pin.pop_front());
                        void'(exp_cyc.pop_front());
                    end
                end
            end
        end
    end

    task automatic set_active(int p, bit act);
        pin_in[p] = act ^ pin_fall_active[p];
    endtask

    // Driver: one active pulse of len cycles, optionally expecting a strobe.
    task automatic pulse(int p, int len, bit expect_ev);
        @(negedge clk);
        set_active(p, 1'b1);
        if (expect_ev) begin
            exp_pin.push_back(p);
            exp_cyc.push_back(cyc + LAT);
        end
        repeat (len) @(negedge clk);
        set_active(p, 1'b0);
        repeat (12) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        sts_clr_wr = 1'b1;
        sts_clr_mask = '1;
        @(negedge clk);
        sts_clr_wr = 1'b0;
        sts_clr_mask = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_status == '0, "R1 status after reset", irq_status, 0);
        chk(cap_strobe == '0, "R1 strobe after reset", cap_strobe, 0);
        chk(irq_out == 1'b0, "R1 irq after reset", irq_out, 0);

        // R2 / R7 / R9: threshold-length pulse on pin 0.
        pulse(0, 5, 1'b1);
        chk(irq_status == 3'b001, "R7 capture bit set", irq_status, 3'b001);
        chk(irq_out == 1'b1, "R9 irq raised", irq_out, 1);
        clear_all();
        @(negedge clk);
        chk(irq_status == '0, "R7 write-one-to-clear", irq_status, 0);

        // R3: one cycle short of the threshold.
        pulse(0, 4, 1'b0);
        chk(irq_status == '0, "R3 short pulse ignored", irq_status, 0);

        // R2 on pin 1, rising polarity.
        pulse(1, 5, 1'b1);
        chk(irq_status == 3'b010, "R2 pin1 capture", irq_status, 3'b010);
        clear_all();

        // R4: falling polarity on pin 1; idle level is high.
        @(negedge clk);
        pin_fall_active[1] = 1'b1;
        pin_in[1] = 1'b1;
        repeat (6) @(negedge clk);
        chk(irq_status == '0, "R4 rising edge not active", irq_status, 0);
        pulse(1, 6, 1'b1);
        chk(irq_status == 3'b010, "R4 falling edge capture", irq_status, 3'b010);
        clear_all();
        pulse(1, 3, 1'b0);
        chk(irq_status == '0, "R4 short low pulse ignored", irq_status, 0);

        // R5: long pulse fires once, then re-arms.
        pulse(0, 30, 1'b1);
        pulse(0, 5, 1'b1);
        chk(irq_status[0] == 1'b1, "R5 re-armed capture", irq_status[0], 1);
        clear_all();

        // R6: pin not configured as input.
        @(negedge clk);
        pin_is_input[0] = 1'b0;
        pulse(0, 10, 1'b0);
        chk(irq_status == '0, "R6 disabled pin ignored", irq_status, 0);
        pin_is_input[0] = 1'b1;
        repeat (4) @(negedge clk);

        // R8: timer bit set, then cleared by an event.
        @(negedge clk);
        timer_int_set = 1'b1;
        @(negedge clk);
        timer_int_set = 1'b0;
        chk(irq_status[2] == 1'b1, "R8 timer bit set", irq_status[2], 1);
        timer_clr_en = 1'b1;
        pulse(1, 5, 1'b1);
        chk(irq_status == 3'b010, "R8 event clears timer", irq_status, 3'b010);
        clear_all();
        @(negedge clk);
        timer_int_set = 1'b1;
        timer_clr_en = 1'b0;
        @(negedge clk);
        timer_int_set = 1'b0;
        pulse(0, 5, 1'b1);
        chk(irq_status == 3'b101, "R8 timer kept when clear disabled", irq_status, 3'b101);
        // R8: hardware set beats software clear.
        @(negedge clk);
        timer_int_set = 1'b1;
        sts_clr_wr = 1'b1;
        sts_clr_mask = 3'b100;
        @(negedge clk);
        timer_int_set = 1'b0;
        sts_clr_wr = 1'b0;
        sts_clr_mask = '0;
        chk(irq_status[2] == 1'b1, "R8 set wins over clear", irq_status[2], 1);
        clear_all();
        timer_clr_en = 1'b1;

        // R7: set and clear of the same capture bit in one cycle.
        @(negedge clk);
        set_active(0, 1'b1);
        exp_pin.push_back(0);
        exp_cyc.push_back(cyc + LAT);
        repeat (5) @(negedge clk);
        set_active(0, 1'b0);
        repeat (2) @(negedge clk);
        sts_clr_wr = 1'b1;
        sts_clr_mask = 3'b001;
        @(negedge clk);
        sts_clr_wr = 1'b0;
        sts_clr_mask = '0;
        chk(irq_status[0] == 1'b1, "R7 set wins over clear", irq_status[0], 1);

        // R9: enable masking.
        irq_en = 3'b110;
        #1;
        chk(irq_out == 1'b0, "R9 masked bit gives no irq", irq_out, 0);
        irq_en = 3'b001;
        #1;
        chk(irq_out == 1'b1, "R9 enabled bit gives irq", irq_out, 1);

        repeat (10) @(negedge clk);
        chk(exp_cyc.size() == 0, "R2 scoreboard drained", exp_cyc.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule